// File: doc/BRIEF.md
# LPC memory-cycle target

This block is the target side of a Low Pin Count bus for memory transfers. It samples a 4-bit multiplexed address/data bus and an active-low frame strobe on each rising edge of the bus clock. It recognises memory read and write cycles and gathers a 32-bit address as eight nibbles. On writes it also gathers one data byte. It then hands each request to a byte-wide backend port that has one-clock read and write strobes and a ready input.

Once the host has turned the bus around, the target drives a handshake nibble. While the backend is busy it drives a wait code. When the backend is done it drives the ready code, followed on reads by the data byte. A driven turnaround nibble closes the exchange, and the bus is then released.

The block does not respond at all in three cases:
- the address falls outside a parameterised decode window;
- the cycle-type nibble does not name a memory cycle;
- the host pulls the frame strobe low partway through a cycle.

When the backend stays busy beyond a parameterised number of wait nibbles, the target gives up and releases the bus.

Top module: `lpc_mem_target`

## Requirements
- R1: After reset, lad_oe is 0, lad_out reads 1111b, and be_rd and be_wr are 0.
- R2: A cycle starts only on a rising clock edge where frame_n is 0 and lad_in is 0000b. If several such nibbles arrive back to back, the cycle-type nibble is the one sampled on the first edge with frame_n at 1. A frame_n low with any other lad_in value starts nothing.
- R3: Bits 3:2 of the cycle-type nibble must be 01b for the target to respond. Bit 1 selects write (1) or read (0). Bit 0 has no effect.
- R4: The eight address nibbles arrive on consecutive clocks, bits 31:28 first. be_addr carries the full address while the request strobe is high.
- R5: On a write, the data byte arrives in the two clocks after the address, low nibble first. be_wr is high for exactly one clock, in clock 13 counted from START as clock 1, with be_wdata holding the byte.
- R6: On a write whose backend is ready in time, the target behaves as follows:
  - lad_oe stays 0 through clocks 1 to 14;
  - it drives 0000b in clock 15 and 1111b in clock 16;
  - it releases the bus (lad_oe 0) from clock 17.
- R7: On a read whose backend is ready in time, the target behaves as follows:
  - be_rd is high only in clock 11;
  - the target drives 0000b in clock 13;
  - it drives the byte low nibble in clock 14 and high nibble in clock 15;
  - it drives 1111b in clock 16 and releases the bus in clock 17.
- R8: Suppose be_ready has not been sampled high since the strobe by the end of the host's second turnaround clock. The target then drives 0101b in each following clock. It drives 0000b in the clock after the edge that samples be_ready high, and the rest of the cycle shifts later by the same amount.
- R9: At most MAX_WAIT wait nibbles are driven. If be_ready is still low at the end of the last one, the target releases the bus in the next clock and returns to idle without a ready nibble.
- R10: A cycle is claimed only when address bits above WIN_SPAN_LOG2 equal those of WIN_BASE (defaults FFF80000h and 19). Otherwise no backend strobe is issued and lad_oe stays 0 for the whole cycle.
- R11: When frame_n is sampled 0 in the middle of a cycle, the cycle is dropped:
  - no further strobe is issued;
  - lad_oe is 0 from the next clock;
  - this holds even when be_ready is sampled high on the same edge;
  - if lad_in was 0000b on that edge, it counts as a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all fields sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Multiplexed bus value seen at the target |
| lad_out | output | 4 | Value the target drives onto the bus (1111b when released) |
| lad_oe | output | 1 | Registered drive enable for lad_out |
| be_addr | output | 32 | Backend byte address |
| be_wdata | output | 8 | Backend write byte |
| be_wr | output | 1 | One-clock backend write strobe |
| be_rd | output | 1 | One-clock backend read strobe |
| be_rdata | input | 8 | Backend read byte, valid while be_ready is high |
| be_ready | input | 1 | Backend completion pulse |

## Verification
Two events can land on the same rising edge.

**Backend completion and the handshake decision.** The edge that ends the host's second turnaround clock decides between ready and wait. The bench sets the backend latency to one and then two clocks after the strobe. It expects a ready nibble at once in the first case and exactly one wait nibble in the second.

**Host abort and backend completion.** The bench makes the host pull frame_n low on the very edge where be_ready is sampled high during a wait. It expects the abort to win: lad_oe is 0 in the next clock and no ready nibble appears.

The bench compares every bus clock against a behavioural timeline computed from the backend latency and the decode window.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_WDATA,
    ST_TARH,
    ST_WAIT,
    ST_SYNC,
    ST_RDATA,
    ST_TART
  } lpc_state_e;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] NIB_READY = 4'h0;
  localparam logic [3:0] NIB_WAIT  = 4'h5;
  localparam logic [3:0] NIB_TURN  = 4'hF;
  localparam logic [1:0] MEM_KIND  = 2'b01;
endpackage

// File: rtl/lpc_nibble_shift.sv
module lpc_nibble_shift #(
  parameter int WIDTH     = 32,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [3:0]       nib,
  output logic [WIDTH-1:0] value,
  output logic [WIDTH-1:0] value_nxt
);
  logic [WIDTH-1:0] value_q;

  generate
    if (MSB_FIRST) begin : g_msb
      assign value_nxt = {value_q[WIDTH-5:0], nib};
    end else begin : g_lsb
      assign value_nxt = {nib, value_q[WIDTH-1:4]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) value_q <= '0;
    else if (load_en) value_q <= value_nxt;
  end

  assign value = value_q;
endmodule

// File: rtl/lpc_win_decode.sv
module lpc_win_decode #(
  parameter int               ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE     = 32'hFFF8_0000,
  parameter int               SPAN_LOG2 = 19
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] TAG_MASK = ~((ADDR_W'(1) << SPAN_LOG2) - ADDR_W'(1));

  assign hit = ((addr ^ BASE) & TAG_MASK) == '0;
endmodule

// File: rtl/lpc_wait_ctr.sv
module lpc_wait_ctr #(
  parameter int MAX_WAIT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_WAIT + 2);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_WAIT);

  logic [CW-1:0] cnt_q;

  assign at_limit = cnt_q >= LIMIT;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (clear) cnt_q <= CW'(1);
    else if (inc && !at_limit) cnt_q <= cnt_q + CW'(1);
  end

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (MAX_WAIT > 0) |-> (cnt_q <= LIMIT));
endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
  import lpc_tgt_pkg::*;
#(
  parameter logic [31:0] WIN_BASE      = 32'hFFF8_0000,
  parameter int          WIN_SPAN_LOG2 = 19,
  parameter int          MAX_WAIT      = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_n,
  input  logic [3:0]  lad_in,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  output logic [31:0] be_addr,
  output logic [7:0]  be_wdata,
  output logic        be_wr,
  output logic        be_rd,
  input  logic [7:0]  be_rdata,
  input  logic        be_ready
);
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 8;
  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int DATA_NIBS = DATA_W / 4;
  localparam int TURN_CLKS = 2;
  localparam int CNT_W     = $clog2(ADDR_NIBS);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CLKS - 1);

  lpc_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             is_wr_q, is_wr_n;
  logic             issue_rd, issue_wr;
  logic             wait_clr, wait_inc, wait_full;
  logic             done_q;
  logic [7:0]       rdata_q;
  logic             win_hit;
  logic [31:0]      addr_nxt;
  logic [7:0]       wdata_nxt;
  logic             ready_now;
  logic             oe_d;
  logic [3:0]       out_d;

  lpc_nibble_shift #(.WIDTH(ADDR_W), .MSB_FIRST(1'b1)) i_addr_shift (
    .clk      (clk),
    .rst      (rst),
    .load_en  (state_q == ST_ADDR && frame_n),
    .nib      (lad_in),
    .value    (be_addr),
    .value_nxt(addr_nxt)
  );

  lpc_nibble_shift #(.WIDTH(DATA_W), .MSB_FIRST(1'b0)) i_data_shift (
    .clk      (clk),
    .rst      (rst),
    .load_en  (state_q == ST_WDATA && frame_n),
    .nib      (lad_in),
    .value    (be_wdata),
    .value_nxt(wdata_nxt)
  );

  lpc_win_decode #(.ADDR_W(ADDR_W), .BASE(WIN_BASE), .SPAN_LOG2(WIN_SPAN_LOG2)) i_win (
    .addr(addr_nxt),
    .hit (win_hit)
  );

  lpc_wait_ctr #(.MAX_WAIT(MAX_WAIT)) i_wait (
    .clk     (clk),
    .rst     (rst),
    .clear   (wait_clr),
    .inc     (wait_inc),
    .at_limit(wait_full)
  );

  assign ready_now = done_q | be_ready;

  // field sequencer: a low frame strobe overrides every state
  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    is_wr_n  = is_wr_q;
    issue_rd = 1'b0;
    issue_wr = 1'b0;
    wait_clr = 1'b0;
    wait_inc = 1'b0;
    if (!frame_n) begin
      state_n = (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
      cnt_n   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_CTYPE: begin
          cnt_n = '0;
          if (lad_in[3:2] == MEM_KIND) begin
            state_n = ST_ADDR;
            is_wr_n = lad_in[1];
          end else begin
            state_n = ST_IDLE;
          end
        end
        ST_ADDR: begin
          if (cnt_q == ADDR_LAST) begin
            cnt_n = '0;
            if (!win_hit) state_n = ST_IDLE;
            else if (is_wr_q) state_n = ST_WDATA;
            else begin
              state_n  = ST_TARH;
              issue_rd = 1'b1;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_WDATA: begin
          if (cnt_q == DATA_LAST) begin
            cnt_n    = '0;
            state_n  = ST_TARH;
            issue_wr = 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_TARH: begin
          if (cnt_q == TURN_LAST) begin
            cnt_n = '0;
            if (ready_now) state_n = ST_SYNC;
            else if (MAX_WAIT > 0) begin
              state_n  = ST_WAIT;
              wait_clr = 1'b1;
            end else begin
              state_n = ST_IDLE;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (ready_now) state_n = ST_SYNC;
          else if (wait_full) state_n = ST_IDLE;
          else wait_inc = 1'b1;
        end
        ST_SYNC: begin
          cnt_n   = '0;
          state_n = is_wr_q ? ST_TART : ST_RDATA;
        end
        ST_RDATA: begin
          if (cnt_q == DATA_LAST) begin
            cnt_n   = '0;
            state_n = ST_TART;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_TART: state_n = ST_IDLE;
        default: state_n = ST_IDLE;
      endcase
    end
  end

  // drive value for the next clock, derived from the next state
  always_comb begin
    oe_d  = 1'b0;
    out_d = NIB_TURN;
    unique case (state_n)
      ST_WAIT:  begin oe_d = 1'b1; out_d = NIB_WAIT;  end
      ST_SYNC:  begin oe_d = 1'b1; out_d = NIB_READY; end
      ST_RDATA: begin
        oe_d  = 1'b1;
        out_d = (cnt_n == '0) ? rdata_q[3:0] : rdata_q[7:4];
      end
      ST_TART:  begin oe_d = 1'b1; out_d = NIB_TURN;  end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      is_wr_q <= 1'b0;
      lad_oe  <= 1'b0;
      lad_out <= NIB_TURN;
      be_rd   <= 1'b0;
      be_wr   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      is_wr_q <= is_wr_n;
      lad_oe  <= oe_d;
      lad_out <= out_d;
      be_rd   <= issue_rd;
      be_wr   <= issue_wr;
    end
  end

  // sticky completion flag and captured read byte
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else if (issue_rd || issue_wr) begin
      done_q <= 1'b0;
    end else if ((state_q == ST_TARH || state_q == ST_WAIT) && be_ready && !done_q) begin
      done_q  <= 1'b1;
      rdata_q <= be_rdata;
    end
  end

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    be_wr |=> !be_wr);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({be_wr, be_rd}));

  // R11
  abort_release_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> !lad_oe);

  // R8
  sync_lead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lad_oe) |-> (lad_out == NIB_READY || lad_out == NIB_WAIT));

  // R10
  rd_window_chk: assert property (@(posedge clk) disable iff (rst)
    (be_rd || be_wr) |-> (((be_addr ^ WIN_BASE) >> WIN_SPAN_LOG2) == '0));

  // R11
  strobe_after_abort_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> !(be_rd || be_wr));
endmodule

// File: tb/test_lpc_mem_target.sv
`timescale 1ns/1ps
module test_lpc_mem_target;
  localparam logic [31:0] BASE = 32'hFFF8_0000;
  localparam int SPAN = 19;
  localparam int MAXW = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic        frame_n;
  logic [3:0]  lad_in;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic [31:0] be_addr;
  logic [7:0]  be_wdata;
  logic        be_wr, be_rd;
  logic [7:0]  be_rdata;
  logic        be_ready;

  int errors = 0;
  int checks = 0;
  int lat = 0;
  int bcnt = 0;

  always #4 clk = ~clk;

  lpc_mem_target #(.WIN_BASE(BASE), .WIN_SPAN_LOG2(SPAN), .MAX_WAIT(MAXW)) i_lpc_mem_target (
    .clk(clk), .rst(rst), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe),
    .be_addr(be_addr), .be_wdata(be_wdata), .be_wr(be_wr), .be_rd(be_rd),
    .be_rdata(be_rdata), .be_ready(be_ready)
  );

  function automatic logic [7:0] mem_of(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // backend model: ready pulse lat clocks after the strobe clock
  initial begin
    be_ready = 1'b0;
    be_rdata = 8'h00;
    forever begin
      @(negedge clk);
      be_ready = 1'b0;
      if (be_rd || be_wr) begin
        if (lat <= 0) begin
          be_ready = 1'b1;
          be_rdata = mem_of(be_addr);
        end else bcnt = lat;
      end else if (bcnt > 0) begin
        bcnt--;
        if (bcnt == 0) begin
          be_ready = 1'b1;
          be_rdata = mem_of(be_addr);
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one bus clock: check outputs for this clock, then drive host inputs
  task automatic step(logic fr, logic [3:0] ld, logic eoe, logic [3:0] elad, int estb, string tag);
    @(negedge clk);
    chk(lad_oe === eoe, tag, "lad_oe", int'(lad_oe), int'(eoe));
    if (eoe) chk(lad_out === elad, tag, "lad_out", int'(lad_out), int'(elad));
    chk(be_rd === (estb == 1), tag, "be_rd", int'(be_rd), int'(estb == 1));
    chk(be_wr === (estb == 2), tag, "be_wr", int'(be_wr), int'(estb == 2));
    frame_n = fr;
    lad_in  = ld;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b1, 4'hF, 1'b0, 4'hF, 0, "R1 idle");
  endtask

  // full host cycle; clock 1 is the last START nibble
  task automatic run_cycle(logic [3:0] ctype, logic [31:0] a, logic [7:0] wd, int l,
                           int nstart, int abort_at, string tag);
    bit is_mem, wr, hit, tmo, valid;
    int w, wn, s, e, estb;
    logic fr, eoe;
    logic [3:0] ld, elad;
    logic [7:0] rb;
    lat    = l;
    is_mem = (ctype[3:2] == 2'b01);
    wr     = ctype[1];
    hit    = is_mem && (((a ^ BASE) >> SPAN) == 0);
    w      = (l > 1) ? l - 1 : 0;
    tmo    = (w > MAXW);
    wn     = tmo ? MAXW : w;
    s      = wr ? 15 : 13;
    rb     = mem_of(a);
    if (!hit) e = 17;
    else if (tmo) e = s + MAXW;
    else e = wr ? s + w + 2 : s + w + 4;
    if (abort_at > 0) e = abort_at + 1;
    for (int i = 1; i < nstart; i++) step(1'b0, 4'h0, 1'b0, 4'hF, 0, tag);
    for (int k = 1; k <= e; k++) begin
      fr = 1'b1;
      ld = 4'hF;
      if (k == abort_at) begin fr = 1'b0; ld = 4'h1; end
      else if (k == 1) begin fr = 1'b0; ld = 4'h0; end
      else if (k == 2) ld = ctype;
      else if (k <= 10) ld = 4'((a >> (4 * (10 - k))) & 32'hF);
      else if (wr && k == 11) ld = wd[3:0];
      else if (wr && k == 12) ld = wd[7:4];
      eoe   = 1'b0;
      elad  = 4'hF;
      estb  = 0;
      valid = hit && (abort_at == 0 || k <= abort_at);
      if (valid) begin
        if (!wr && k == 11) estb = 1;
        if (wr && k == 13) estb = 2;
        if (k >= s && k < s + wn) begin eoe = 1'b1; elad = 4'h5; end
        if (!tmo) begin
          if (k == s + w) begin eoe = 1'b1; elad = 4'h0; end
          if (wr && k == s + w + 1) begin eoe = 1'b1; elad = 4'hF; end
          if (!wr && k == s + w + 1) begin eoe = 1'b1; elad = rb[3:0]; end
          if (!wr && k == s + w + 2) begin eoe = 1'b1; elad = rb[7:4]; end
          if (!wr && k == s + w + 3) begin eoe = 1'b1; elad = 4'hF; end
        end
      end
      step(fr, ld, eoe, elad, estb, tag);
      if (estb != 0) chk(be_addr === a, "R4", "be_addr", int'(be_addr), int'(a));
      if (estb == 2) chk(be_wdata === wd, "R5", "be_wdata", int'(be_wdata), int'(wd));
    end
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    frame_n = 1'b1;
    lad_in = 4'hF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(lad_oe === 1'b0, "R1", "lad_oe", int'(lad_oe), 0);
    chk(lad_out === 4'hF, "R1", "lad_out", int'(lad_out), 15);
    chk(be_rd === 1'b0 && be_wr === 1'b0, "R1", "strobes", int'({be_rd, be_wr}), 0);
    idle(2);

    // basic read and write, ready without delay
    run_cycle(4'h4, 32'hFFF8_1234, 8'h00, 0, 1, 0, "R7");
    run_cycle(4'h6, 32'hFFFF_FFFF, 8'hA5, 0, 1, 0, "R6");
    // ready exactly at / one past the handshake decision edge
    run_cycle(4'h4, 32'hFFF9_00C3, 8'h00, 1, 1, 0, "R8");
    run_cycle(4'h4, 32'hFFF9_00C4, 8'h00, 2, 1, 0, "R8");
    run_cycle(4'h6, 32'hFFFA_5501, 8'h3E, 4, 1, 0, "R8");
    // wait limit: exactly at the limit, then beyond it
    run_cycle(4'h4, 32'hFFFB_7777, 8'h00, MAXW + 1, 1, 0, "R9");
    run_cycle(4'h4, 32'hFFFB_7778, 8'h00, 20, 1, 0, "R9");
    idle(25);
    run_cycle(4'h6, 32'hFFFC_0001, 8'h5A, 20, 1, 0, "R9");
    idle(25);
    // decode window edges
    run_cycle(4'h4, 32'hFFF7_FFFF, 8'h00, 0, 1, 0, "R10");
    run_cycle(4'h6, 32'h0000_1000, 8'h77, 0, 1, 0, "R10");
    run_cycle(4'h4, 32'hFFF8_0000, 8'h00, 0, 1, 0, "R10");
    // cycle-type decode
    run_cycle(4'h5, 32'hFFF8_4242, 8'h00, 0, 1, 0, "R3");
    run_cycle(4'h7, 32'hFFF8_4243, 8'hC9, 0, 1, 0, "R3");
    run_cycle(4'h0, 32'hFFF8_4244, 8'h00, 0, 1, 0, "R3");
    run_cycle(4'hE, 32'hFFF8_4245, 8'h12, 0, 1, 0, "R3");
    run_cycle(4'h2, 32'hFFF8_4246, 8'h34, 0, 1, 0, "R3");
    // repeated START nibbles
    run_cycle(4'h4, 32'hFFFE_1357, 8'h00, 0, 3, 0, "R2");
    run_cycle(4'h6, 32'hFFFE_2468, 8'h81, 1, 2, 0, "R2");
    // frame low with a non-START value starts nothing
    step(1'b0, 4'h3, 1'b0, 4'hF, 0, "R2");
    step(1'b1, 4'h4, 1'b0, 4'hF, 0, "R2");
    for (int k = 0; k < 8; k++) step(1'b1, 4'hF, 1'b0, 4'hF, 0, "R2");
    idle(12);
    // aborts
    run_cycle(4'h4, 32'hFFF8_9999, 8'h00, 0, 1, 7, "R11");
    run_cycle(4'h6, 32'hFFF8_9998, 8'h44, 0, 1, 12, "R11");
    run_cycle(4'h4, 32'hFFF8_9997, 8'h00, 20, 1, 14, "R11");
    idle(25);
    run_cycle(4'h4, 32'hFFF8_9996, 8'h00, 4, 1, 15, "R11");
    idle(10);
    // abort whose frame-low nibble is a new START
    step(1'b0, 4'h0, 1'b0, 4'hF, 0, "R11");
    step(1'b1, 4'h4, 1'b0, 4'hF, 0, "R11");
    for (int k = 0; k < 4; k++) step(1'b1, 4'hF, 1'b0, 4'hF, 0, "R11");
    run_cycle(4'h4, 32'hFFF8_ABCD, 8'h00, 0, 1, 0, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule